// File: doc/BRIEF.md
# Pseudorandom Memory Fill Engine

This block writes a pseudorandom byte into every location of a 256-entry, 8-bit-wide memory when it sees a one-cycle start pulse. The values come from an 8-bit maximal-length Fibonacci linear feedback shift register. A synchronous soft reset loads the register with a fixed nonzero seed. The register then runs on from fill to fill.

Between two stored words the generator takes eight shift steps. Consecutive stored values are therefore not just shifted copies of each other. The block drives a write port (address, data, enable) toward a memory. It raises `busy` so that an outside arbiter can keep other users off the memory, and it marks the end of a fill with a one-cycle `done` pulse.

Top module: `lfsr_ram_filler`

## Requirements
- R1: While `softRst` is high, and in the first cycle after it drops, `busy`, `done` and `wrEn` are 0 and `wrAddr` is 0.
- R2: The generator shifts toward bit 0. The new bit 7 is the XOR of bits 0, 2, 3 and 4 (polynomial x^8+x^6+x^5+x^4+1). Soft reset loads the seed 8'h01, so the first word of the first fill after reset is 8'h71.
- R3: Each written word is the generator state after exactly eight further steps. The sequence carries on across fills and is not reseeded by start.
- R4: A fill writes each address once, in ascending order from 0x00 to 0xFF.
- R5: The first write is presented 9 cycles after the edge that samples start. Later writes follow every 9 cycles: 8 step cycles, then 1 write cycle.
- R6: `busy` is high from the cycle after start is sampled through the cycle of the last write.
- R7: `done` is high for exactly one cycle, the cycle right after the last write, and `busy` is low in that cycle.
- R8: A start pulse sampled while `busy` or `done` is high has no effect. The write sequence continues unchanged, and no new fill begins after `done`.
- R9: The generator never holds zero. Words 0 to 254 of a fill are 255 distinct nonzero values, and word 255 equals word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| softRst | input | 1 | Synchronous soft reset, active high |
| start | input | 1 | One-cycle request to begin a fill |
| busy | output | 1 | A fill is in progress and owns the memory |
| done | output | 1 | One-cycle pulse after the final write |
| wrEn | output | 1 | Memory write enable |
| wrAddr | output | 8 | Memory write address |
| wrData | output | 8 | Memory write data |

## Verification
The hardest case to reach from the ports is a start pulse that lands while a fill is already running. A restart here would quietly reset the address and the step counter, and the values written would still look random. The bench therefore injects start in the middle of the step phase of one fill, and again in the `done` cycle. It compares every write cycle by cycle against an independent generator model, so any address jump or phase slip shows up at once. A soft reset in the middle of a fill, followed by a fresh fill, checks that the seed is reloaded.

// File: rtl/filler_pkg.sv
package filler_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } fillState_t;

  typedef struct packed {
    logic clear;  // zero the address counter at launch
    logic step;   // advance the generator one shift
    logic write;  // present a word and bump the address
  } ctrlStrobes_t;

endpackage

// File: rtl/filler_ctrl.sv
module filler_ctrl
  import filler_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic         clk,
  input  logic         softRst,
  input  logic         start,
  input  logic         addrLast,
  output ctrlStrobes_t ctl,
  output logic         busy,
  output logic         done
);

  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEPS - 1);

  fillState_t state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start) stateNext = ST_STEP;
      ST_STEP:  if (stepCnt == CNT_LAST) stateNext = ST_WRITE;
      ST_WRITE: stateNext = addrLast ? ST_FIN : ST_STEP;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (softRst) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_STEP)
        stepCnt <= (stepCnt == CNT_LAST) ? '0 : stepCnt + 1'b1;
      else
        stepCnt <= '0;
    end
  end

  always_comb begin
    ctl.clear = (state == ST_IDLE) && start;
    ctl.step  = (state == ST_STEP);
    ctl.write = (state == ST_WRITE);
  end

  assign busy = (state == ST_STEP) || (state == ST_WRITE);
  assign done = (state == ST_FIN);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (softRst)
    done |=> !done);
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (softRst)
    done |-> !busy);
  assert_last_write_ends_R7: assert property (@(posedge clk) disable iff (softRst)
    (ctl.write && addrLast) |=> done);
  assert_write_gap_R5: assert property (@(posedge clk) disable iff (softRst)
    ctl.write |=> (!ctl.write && (ctl.step || done)));
  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (softRst)
    busy |=> (busy || done));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (softRst)
    (busy && start && !(ctl.write && addrLast)) |=> busy);

endmodule

// File: rtl/filler_dp.sv
module filler_dp
  import filler_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               ADDR_W   = 8,
  parameter logic [DATA_W-1:0] SEED    = 8'h01,
  parameter logic [DATA_W-1:0] TAP_MASK = 8'b0001_1101
) (
  input  logic              clk,
  input  logic              softRst,
  input  ctrlStrobes_t      ctl,
  output logic              addrLast,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] lfsr;
  logic [ADDR_W-1:0] addr;
  logic              feedback;

  // Fibonacci form: shift toward bit 0, parity of tapped bits enters the top
  assign feedback = ^(lfsr & TAP_MASK);

  always_ff @(posedge clk) begin
    if (softRst)
      lfsr <= SEED;
    else if (ctl.step)
      lfsr <= {feedback, lfsr[DATA_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (softRst || ctl.clear)
      addr <= '0;
    else if (ctl.write)
      addr <= addr + 1'b1;
  end

  assign addrLast = &addr;
  assign wrAddr   = addr;
  assign wrData   = lfsr;

  assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (softRst)
    lfsr != '0);
  assert_lfsr_hold_R3: assert property (@(posedge clk) disable iff (softRst)
    !ctl.step |=> (lfsr == $past(lfsr)));
  assert_addr_advance_R4: assert property (@(posedge clk) disable iff (softRst)
    (ctl.write && !ctl.clear) |=> (wrAddr == $past(wrAddr) + 1'b1));
  assert_addr_still_R4: assert property (@(posedge clk) disable iff (softRst)
    (ctl.step && !ctl.write) |=> $stable(wrAddr));

endmodule

// File: rtl/lfsr_ram_filler.sv
module lfsr_ram_filler
  import filler_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter int               ADDR_W   = 8,
  parameter logic [DATA_W-1:0] SEED    = 8'h01,
  parameter logic [DATA_W-1:0] TAP_MASK = 8'b0001_1101
) (
  input  logic              clk,
  input  logic              softRst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam int STEPS = DATA_W;

  ctrlStrobes_t ctl;
  logic         addrLast;

  filler_ctrl #(.STEPS(STEPS)) i_ctrl (
    .clk      (clk),
    .softRst  (softRst),
    .start    (start),
    .addrLast (addrLast),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  filler_dp #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SEED     (SEED),
    .TAP_MASK (TAP_MASK)
  ) i_dp (
    .clk      (clk),
    .softRst  (softRst),
    .ctl      (ctl),
    .addrLast (addrLast),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );

  assign wrEn = ctl.write;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    softRst |=> (!busy && !done && !wrEn && wrAddr == '0));
  assert_write_in_busy_R6: assert property (@(posedge clk) disable iff (softRst)
    wrEn |-> busy);

endmodule

// File: tb/test_lfsr_ram_filler.sv
module test_lfsr_ram_filler;

  localparam int PERIOD   = 9;
  localparam int WORDS    = 256;
  localparam int LAST_WR  = PERIOD * WORDS;   // 2304
  localparam int DONE_J   = LAST_WR + 1;      // 2305
  localparam int SPOT_N   = 8;
  localparam int SPOT_IDX [SPOT_N] = '{0, 1, 2, 3, 127, 128, 254, 255};

  logic       clk = 1'b0;
  logic       softRst = 1'b1;
  logic       start = 1'b0;
  logic       busy, done, wrEn;
  logic [7:0] wrAddr, wrData;

  int         nChecks = 0;
  int         nFails  = 0;
  logic [7:0] model;
  logic [7:0] expMem [WORDS];
  logic [7:0] capMem [WORDS];

  always #5 clk = ~clk;

  lfsr_ram_filler i_lfsr_ram_filler (
    .clk(clk), .softRst(softRst), .start(start), .busy(busy), .done(done),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  function automatic logic [7:0] nextState(input logic [7:0] s);
    return {s[0] ^ s[2] ^ s[3] ^ s[4], s[7:1]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string req);
    check(req, busy, 0);
    check(req, done, 0);
    check(req, wrEn, 0);
  endtask

  // Runs one fill from a start pulse; injects extra start at midJ and optionally at done.
  task automatic runFill(input int midJ, input bit startAtDone, input int lastJ);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int j = 1; j <= lastJ; j++) begin
      if (j > 1) @(negedge clk);
      start = (j == midJ) || (startAtDone && j == DONE_J);
      begin
        bit expWr;
        expWr = (j % PERIOD == 0) && (j <= LAST_WR);
        check("R5 wrEn timing", wrEn, expWr);
        check("R6 busy", busy, j <= LAST_WR);
        check("R7 done", done, j == DONE_J);
        if (expWr) begin
          for (int k = 0; k < PERIOD - 1; k++) model = nextState(model);
          expMem[j / PERIOD - 1] = model;
          check("R4 address order", wrAddr, j / PERIOD - 1);
          check("R3 word value", wrData, model);
        end
        if (wrEn) capMem[wrAddr] = wrData;
        if (j > DONE_J) check("R8 no restart after done", busy, 0);
      end
    end
    start = 1'b0;
  endtask

  task automatic checkSpread();
    for (int a = 0; a < WORDS; a++) begin
      if (a < WORDS - 1) check("R9 nonzero", capMem[a] != 8'h00, 1);
      for (int b = a + 1; b < WORDS - 1; b++)
        if (capMem[a] == capMem[b]) check("R9 distinct", {capMem[a], 8'(b)}, -1);
    end
    check("R9 wrap word", capMem[WORDS-1], capMem[0]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    check("R1 addr", wrAddr, 0);
    softRst = 1'b0;
    @(negedge clk);
    checkIdle("R1 after reset");
    check("R1 addr", wrAddr, 0);
    model = 8'h01;

    // Fill 1 with a start in the step phase and another in the done cycle (R8)
    runFill(100, 1'b1, DONE_J + 5);
    check("R2 first word after seed", capMem[0], 8'h71);

    // Table walk over spot addresses of fill 1
    for (int i = 0; i < SPOT_N; i++)
      check("R3 spot table", capMem[SPOT_IDX[i]], expMem[SPOT_IDX[i]]);
    checkSpread();

    // Fill 2 continues the sequence, no reseed (R3)
    runFill(0, 1'b0, DONE_J + 2);
    for (int i = 0; i < SPOT_N; i++)
      check("R3 continued spot table", capMem[SPOT_IDX[i]], expMem[SPOT_IDX[i]]);
    checkSpread();

    // Soft reset mid fill reloads the seed (R1, R2)
    runFill(0, 1'b0, 60);
    @(negedge clk) softRst = 1'b1;
    @(negedge clk) softRst = 1'b0;
    @(negedge clk);
    checkIdle("R1 after mid-fill reset");
    check("R1 addr after mid-fill reset", wrAddr, 0);
    model = 8'h01;
    runFill(0, 1'b0, DONE_J + 1);
    check("R2 reseeded first word", capMem[0], 8'h71);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule